// File: doc/BRIEF.md
# Edge Event Timestamp Capture Unit

This block watches a group of input pins and, for each one, records the moment a chosen edge arrives. A 34-bit counter runs freely on the system clock from reset. When a monitored edge is seen, the channel stores a 32-bit record. The top bit of the record gives the edge direction. The remaining 31 bits are the counter divided by eight, so a timestamp moves on every eighth clock.

Each channel owns one capture register, a data-valid flag and an overrun flag. Once a record is stored, it stays frozen until software clears the valid flag. An edge that arrives while the flag is still set is thrown away and raises the overrun flag instead. All flags sit in one status word, with a matching enable word and a write-one-to-clear word, and the interrupt output combines them. Software reaches everything through a flat word-addressed port with combinational reads and single-cycle writes.

Top module: `edge_stamp_unit`

## Requirements
- R1: The time counter is 34 bits wide and is cleared by reset. It increments by one on every clock edge. A read of address 0 returns counter bits 33:2.
- R2: A capture record has the edge direction in bit 31 (1 for rising, 0 for falling). Bits 30:0 hold counter bits 33:3 as they stood in the cycle before the capture edge. The capture lands on the third rising clock edge after the pin changes (two synchronizer stages, then a compare against the previous sample).
- R3: Channel c has a 2-bit edge select at bits 2c+1:2c of address 1, with 00 = off, 01 = rising, 10 = falling, 11 = both. An edge the channel is not selected for sets no flag and stores nothing.
- R4: A capture sets the channel's valid flag, which is bit c of the status word at address 3. The channel's capture register at address 8+c keeps its value while that flag stays set.
- R5: A selected edge that arrives while the valid flag is set raises the overrun flag, which is bit 16+c of the status word. The stored capture is left unchanged.
- R6: Writing to address 4 clears every status bit written as 1. Bits written as 0 are untouched.
- R7: The interrupt output is high exactly when some status bit and the bit in the same position of the enable word at address 2 are both set.
- R8: After reset all flags, capture registers, edge selects and enables read as zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time-counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins | input | NUM_CH | Asynchronous monitored inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted synchronizer or edge detector shows up at the status word within four clocks of a pin change: a flag is missing or spurious, or the direction bit is wrong. A counter fault is visible straight away in the time read, and one capture later in the timestamp field, because the bench predicts both to the exact cycle. A flag that fails to hold or to clear shows in the next status read, and also in the interrupt level under a matching enable.

// File: rtl/esu_pkg.sv
// Shared definitions for the edge stamp unit: register addresses and the
// edge-select encoding. Assumes a word-addressed register port.
package esu_pkg;
    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;

    localparam int ADDR_TIME   = 0;
    localparam int ADDR_SEL    = 1;
    localparam int ADDR_ENABLE = 2;
    localparam int ADDR_STATUS = 3;
    localparam int ADDR_CLEAR  = 4;
    localparam int CAP_BASE    = 8;
    localparam int OVR_BASE    = 16;
endpackage

// File: rtl/esu_timebase.sv
// Free-running time reference. Cleared by synchronous reset and advancing by
// one every clock. Assumes wrap-around is acceptable to consumers.
module esu_timebase #(
    parameter int CNT_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    // Advance the reference count each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/esu_chan.sv
// One capture channel: synchronizes an asynchronous pin, detects the selected
// edge, stores {direction, stamp} and keeps valid and overrun flags. Assumes
// the pin is low during reset, so no edge is seen at reset release.
module esu_chan #(
    parameter int TS_W = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [1:0]    sel,
    input  logic [TS_W-1:0] stamp,
    input  logic          clr_valid,
    input  logic          clr_ovr,
    output logic          valid_q,
    output logic          ovr_q,
    output logic [TS_W:0] cap_q
);
    logic s1, s2, s3;
    logic rise, fall, hit, held;

    // Two-stage synchronizer followed by one previous-sample stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Edge detection qualified by the channel's select field.
    always_comb begin
        rise = s2 & ~s3;
        fall = ~s2 & s3;
        hit  = (rise & sel[0]) | (fall & sel[1]);
        held = valid_q & ~clr_valid;
    end

    // Store a new record only when no unread record is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)            cap_q <= '0;
        else if (hit && !held) cap_q <= {s2, stamp};
    end

    // Valid flag: set by a capture, dropped by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= held | hit;
    end

    // Overrun flag: set by an edge lost to a pending record; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= (ovr_q & ~clr_ovr) | (hit & held);
    end

    assert_capture_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !held |=> valid_q && cap_q[TS_W] == $past(s2));

    assert_off_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b00 && !valid_q |=> !valid_q);

    assert_hold_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && $past(valid_q) && !$past(clr_valid) |-> $stable(cap_q));

    assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && held |=> ovr_q && $stable(cap_q));
endmodule

// File: rtl/edge_stamp_unit.sv
// Top of the edge stamp unit: time base, NUM_CH capture channels and the
// register file. Reads are combinational; writes take effect on the clock
// edge where wr_en is high. Assumes NUM_CH <= 16 and NUM_CH <= 2^ADDR_W - 8.
module edge_stamp_unit
    import esu_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int CNT_W  = 34,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pins,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    localparam int DW   = 32;
    localparam int TS_W = DW - 1;
    localparam int SELW = 2 * NUM_CH;

    logic [CNT_W-1:0]  count;
    logic [SELW-1:0]   sel_q;
    logic [DW-1:0]     en_q;
    logic [DW-1:0]     clr;
    logic [DW-1:0]     status;
    logic [NUM_CH-1:0] valid, ovr;
    logic [DW-1:0]     cap [NUM_CH];

    esu_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    // Clear strobe derived from a write to the clear address.
    always_comb begin
        clr = (wr_en && addr == ADDR_W'(ADDR_CLEAR)) ? wdata : '0;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        esu_chan #(.TS_W(TS_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (pins[c]),
            .sel       (sel_q[2*c +: 2]),
            .stamp     (count[CNT_W-1 -: TS_W]),
            .clr_valid (clr[c]),
            .clr_ovr   (clr[OVR_BASE + c]),
            .valid_q   (valid[c]),
            .ovr_q     (ovr[c]),
            .cap_q     (cap[c])
        );
    end

    // Edge select and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADDR_SEL))    sel_q <= wdata[SELW-1:0];
            if (addr == ADDR_W'(ADDR_ENABLE)) en_q  <= wdata;
        end
    end

    // Assemble the status word from the channel flags.
    always_comb begin
        status = '0;
        status[NUM_CH-1:0]            = valid;
        status[OVR_BASE +: NUM_CH]    = ovr;
    end

    // Interrupt request from enabled status bits.
    always_comb begin
        irq = |(status & en_q);
    end

    // Read multiplexer over the register map.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_TIME):   rdata = count[CNT_W-1 -: DW];
            ADDR_W'(ADDR_SEL):    rdata = DW'(sel_q);
            ADDR_W'(ADDR_ENABLE): rdata = en_q;
            ADDR_W'(ADDR_STATUS): rdata = status;
            default: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (addr == ADDR_W'(CAP_BASE + i)) rdata = cap[i];
            end
        endcase
    end

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid == '0 && ovr == '0) |-> !irq);

    assert_clear_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[NUM_CH-1:0] == {NUM_CH{1'b1}} && sel_q == '0) |=> valid == '0);
endmodule

// File: tb/sim_edge_stamp_unit.sv
module sim_edge_stamp_unit;
    localparam int CLK_P  = 10;
    localparam int NUM_CH = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_CH-1:0] pins = '0;
    logic wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic irq;

    int checks = 0;
    int failures = 0;
    longint bc = 0;
    logic done = 1'b0;

    edge_stamp_unit u0 (
        .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // Bench model of the time counter (R1).
    always @(posedge clk) bc <= rst_n ? bc + 1 : 0;

    // Vector: [7:4] channel, [3:2] edge select, [1] new pin level, [0] capture expected.
    localparam logic [7:0] VEC [8] = '{
        {4'd0,  2'b01, 1'b1, 1'b1},
        {4'd0,  2'b01, 1'b0, 1'b0},
        {4'd1,  2'b10, 1'b1, 1'b0},
        {4'd1,  2'b10, 1'b0, 1'b1},
        {4'd2,  2'b11, 1'b1, 1'b1},
        {4'd2,  2'b11, 1'b0, 1'b1},
        {4'd11, 2'b00, 1'b1, 1'b0},
        {4'd11, 2'b11, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 5'(a);
        #1 d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one pin at a negedge; return the expected record for that edge (R2).
    task automatic edge_pin(input int ch, input logic lvl, output logic [31:0] rec);
        longint b;
        pins[ch] = lvl;
        b = bc;
        rec = {lvl, 31'((b + 2) >> 3)};
        wait_cyc(4);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, rec, c1;
        wait_cyc(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state.
        rd(3, d); chk("R8 status", d, 0);
        rd(1, d); chk("R8 select", d, 0);
        rd(2, d); chk("R8 enable", d, 0);
        rd(8, d); chk("R8 capture0", d, 0);
        chk("R8 irq", 32'(irq), 0);
        rd(0, d); chk("R1 time early", d, 32'(bc >> 2));

        // Table walk: R2, R3, R4.
        foreach (VEC[k]) begin
            int ch;
            ch = int'(VEC[k][7:4]);
            wr(4, 32'hFFFF_FFFF);
            wr(1, 32'(VEC[k][3:2]) << (2 * ch));
            edge_pin(ch, VEC[k][1], rec);
            rd(3, d);
            chk("R3/R4 status after edge", d, VEC[k][0] ? (32'd1 << ch) : 32'd0);
            if (VEC[k][0]) begin
                rd(8 + ch, d);
                chk("R2 capture record", d, rec);
            end
        end

        // R5: overrun keeps the first record.
        wr(4, 32'hFFFF_FFFF);
        wr(1, 32'h3 << 6);
        edge_pin(3, 1'b1, c1);
        wait_cyc(10);
        edge_pin(3, 1'b0, rec);
        rd(3, d); chk("R5 overrun flag", d, (32'd1 << 3) | (32'd1 << 19));
        rd(11, d); chk("R5 capture kept", d, c1);
        chk("R4 direction of kept record", 32'(d[31]), 1);

        // R7: interrupt gating.
        chk("R7 irq masked", 32'(irq), 0);
        wr(2, 32'd1 << 19);
        chk("R7 irq overrun enabled", 32'(irq), 1);

        // R6: write-one-to-clear.
        wr(4, 32'h0);
        rd(3, d); chk("R6 zero write no effect", d, (32'd1 << 3) | (32'd1 << 19));
        wr(4, 32'd1 << 19);
        rd(3, d); chk("R6 overrun cleared only", d, 32'd1 << 3);
        chk("R7 irq low after overrun clear", 32'(irq), 0);
        wr(2, 32'd1 << 3);
        chk("R7 irq valid enabled", 32'(irq), 1);
        wr(4, 32'd1 << 3);
        rd(3, d); chk("R6 valid cleared", d, 0);
        chk("R7 irq low after clear", 32'(irq), 0);

        // R4: a fresh capture after clearing replaces the record.
        edge_pin(3, 1'b1, rec);
        rd(11, d); chk("R4 new record after clear", d, rec);

        // R1: time read after a longer run.
        wait_cyc(1000);
        rd(0, d); chk("R1 time late", d, 32'(bc >> 2));

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule